// File: doc/BRIEF.md
# Signed-Magnitude Adder/Subtractor

This unit adds or subtracts two operands held in sign-and-magnitude form. Each operand is one sign bit (1 = negative) and an unsigned magnitude of `MAG_W` bits, with a default of 8. A one-cycle `start` pulse captures both operands and the operation select. The unit then works on its own, with no further input. When it finishes, it presents the result sign and magnitude, an overflow flag and a one-cycle `done` strobe.

For a subtraction, the unit inverts the sign of the second operand and then runs the same path as an addition. When the effective signs agree, it adds the magnitudes, and the carry out of the top bit becomes the overflow flag. When the effective signs differ, it adds the first magnitude to the two's complement of the second. A carry out then means the first magnitude is the larger or equal one. No carry means the raw result must be negated and the sign flipped. A zero result from a sign-differing pair always comes out positive. A single adder with a bit-wise inverter serves both the main sum and the later negation.

Top module: `sm_addsub`

## Requirements
- R1: After reset, `done`, `res_sign`, `res_mag` and `ovf` are all 0.
- R2: When `sub_mode` = 1, the result equals the addition of the first operand and the second operand with `b_sign` inverted.
- R3: With equal effective signs, `res_mag` is (a_mag + b_mag) mod 2^MAG_W and `res_sign` equals `a_sign`.
- R4: With equal effective signs, `ovf` is 1 exactly when a_mag + b_mag ≥ 2^MAG_W.
- R5: With differing effective signs, `ovf` is 0.
- R6: With differing effective signs and a_mag > b_mag, `res_mag` is a_mag − b_mag and `res_sign` equals `a_sign`.
- R7: With differing effective signs and a_mag < b_mag, `res_mag` is b_mag − a_mag and `res_sign` is the inverse of `a_sign`.
- R8: With differing effective signs and a_mag = b_mag, the result is magnitude 0 with `res_sign` = 0.
- R9: `done` is high for exactly one cycle. It is first seen high after the third rising edge counted from, and including, the edge that samples `start`. The result outputs are valid in that cycle.
- R10: Operands and `sub_mode` are taken only at the edge that samples `start`. Changing them afterwards has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle launch pulse |
| sub_mode | input | 1 | 1 = subtract, 0 = add |
| a_sign | input | 1 | Sign of first operand (1 = negative) |
| a_mag | input | MAG_W | Magnitude of first operand |
| b_sign | input | 1 | Sign of second operand |
| b_mag | input | MAG_W | Magnitude of second operand |
| res_sign | output | 1 | Result sign |
| res_mag | output | MAG_W | Result magnitude |
| ovf | output | 1 | Magnitude overflow of same-sign addition |
| done | output | 1 | Result-valid strobe |

## Verification
Every result, for any operand pattern, is due at a fixed point: the cycle after the third rising edge counted from the edge that samples `start`. The driver records the cycle count at launch together with the expected sign, magnitude and overflow. The monitor samples on falling edges and checks both the values and the arrival cycle. Operand inputs are scrambled right after each launch, so that R10 is exercised on every operation. A `done` strobe with no matching queued item counts as a failure, which catches any strobe wider than one cycle.

// File: rtl/sm_pkg.sv
package sm_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADD  = 2'd1,
        ST_FIX  = 2'd2
    } sm_state_e;
endpackage

// File: rtl/sm_cmpl.sv
module sm_cmpl #(
    parameter int W = 8
) (
    input  logic [W-1:0] din,
    input  logic         inv,
    output logic [W-1:0] dout
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign dout[i] = din[i] ^ inv;
    end
endmodule

// File: rtl/sm_padd.sv
module sm_padd #(
    parameter int W = 8
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);
    localparam int WE = W + 1;
    logic [WE-1:0] full;
    assign full = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};
    assign sum  = full[W-1:0];
    assign cout = full[W];
endmodule

// File: rtl/sm_addsub.sv
module sm_addsub #(
    parameter int MAG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             sub_mode,
    input  logic             a_sign,
    input  logic [MAG_W-1:0] a_mag,
    input  logic             b_sign,
    input  logic [MAG_W-1:0] b_mag,
    output logic             res_sign,
    output logic [MAG_W-1:0] res_mag,
    output logic             ovf,
    output logic             done
);
    import sm_pkg::*;

    typedef struct packed {
        sm_state_e        state;
        logic [MAG_W-1:0] a;
        logic             as;
        logic [MAG_W-1:0] b;
        logic             bs;
        logic             e;
        logic             avf;
        logic             done;
    } regs_t;

    regs_t r_q, r_d;

    logic             eff_sub;
    logic             in_add;
    logic [MAG_W-1:0] cmp_in, cmp_out, add_x, add_sum;
    logic             cmp_inv, add_cin, add_cout;
    sm_state_e        st_q;

    assign st_q    = r_q.state;
    assign eff_sub = r_q.as ^ r_q.bs;
    assign in_add  = (r_q.state == ST_ADD);

    // Shared datapath: main complement-add in ST_ADD, negation of A in ST_FIX
    assign cmp_in  = in_add ? r_q.b : r_q.a;
    assign cmp_inv = in_add ? eff_sub : 1'b1;
    assign add_x   = in_add ? r_q.a : '0;
    assign add_cin = in_add ? eff_sub : 1'b1;

    sm_cmpl #(.W(MAG_W)) u_cmpl (
        .din  (cmp_in),
        .inv  (cmp_inv),
        .dout (cmp_out)
    );

    sm_padd #(.W(MAG_W)) u_padd (
        .x    (add_x),
        .y    (cmp_out),
        .cin  (add_cin),
        .sum  (add_sum),
        .cout (add_cout)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        case (r_q.state)
            ST_IDLE: begin
                if (start) begin
                    r_d.a     = a_mag;
                    r_d.as    = a_sign;
                    r_d.b     = b_mag;
                    r_d.bs    = b_sign ^ sub_mode;
                    r_d.avf   = 1'b0;
                    r_d.state = ST_ADD;
                end
            end
            ST_ADD: begin
                r_d.a     = add_sum;
                r_d.e     = add_cout;
                r_d.avf   = eff_sub ? 1'b0 : add_cout;
                r_d.state = ST_FIX;
            end
            ST_FIX: begin
                if (eff_sub) begin
                    if (!r_q.e) begin
                        r_d.a  = add_sum;
                        r_d.as = ~r_q.as;
                    end else if (r_q.a == '0) begin
                        r_d.as = 1'b0;
                    end
                end
                r_d.done  = 1'b1;
                r_d.state = ST_IDLE;
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign res_sign = r_q.as;
    assign res_mag  = r_q.a;
    assign ovf      = r_q.avf;
    assign done     = r_q.done;
endmodule

// File: rtl/sm_addsub_chk.sv
module sm_addsub_chk #(
    parameter int MAG_W = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start,
    input logic               done,
    input logic               res_sign,
    input logic [MAG_W-1:0]   res_mag,
    input logic               ovf,
    input sm_pkg::sm_state_e  st,
    input logic               eff_sub,
    input logic               e_flag
);
    import sm_pkg::*;

    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r9_done_latency: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(start, 3));

    a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (done && eff_sub) |-> !ovf);

    a_r8_positive_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (done && eff_sub && res_mag == '0) |-> !res_sign);

    a_r7_sign_flip: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_FIX && eff_sub && !e_flag) |=> (res_sign != $past(res_sign)));
endmodule

bind sm_addsub sm_addsub_chk #(.MAG_W(MAG_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .done     (done),
    .res_sign (res_sign),
    .res_mag  (res_mag),
    .ovf      (ovf),
    .st       (st_q),
    .eff_sub  (eff_sub),
    .e_flag   (r_q.e)
);

// File: tb/test_sm_addsub.sv
module test_sm_addsub;
    localparam int  MAG_W  = 8;
    localparam time PERIOD = 10ns;
    localparam int  LAT    = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic             sub_mode = 1'b0;
    logic             a_sign = 1'b0;
    logic [MAG_W-1:0] a_mag = '0;
    logic             b_sign = 1'b0;
    logic [MAG_W-1:0] b_mag = '0;
    logic             res_sign;
    logic [MAG_W-1:0] res_mag;
    logic             ovf;
    logic             done;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 1'b0;

    typedef struct {
        logic             sign;
        logic [MAG_W-1:0] mag;
        logic             ov;
        int               due;
        string            tag;
    } item_t;

    item_t sb[$];

    always #(PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    sm_addsub #(.MAG_W(MAG_W)) i_sm_addsub (
        .clk(clk), .rst_n(rst_n), .start(start), .sub_mode(sub_mode),
        .a_sign(a_sign), .a_mag(a_mag), .b_sign(b_sign), .b_mag(b_mag),
        .res_sign(res_sign), .res_mag(res_mag), .ovf(ovf), .done(done)
    );

    task automatic op(input logic sub, input logic sa, input int ma,
                      input logic sb_, input int mb, input string tag);
        item_t it;
        logic  eb;
        int    sum;
        eb = sb_ ^ sub;
        if (sa == eb) begin
            sum     = ma + mb;
            it.mag  = sum[MAG_W-1:0];
            it.ov   = (sum >= (1 << MAG_W));
            it.sign = sa;
        end else if (ma >= mb) begin
            it.mag  = MAG_W'(ma - mb);
            it.ov   = 1'b0;
            it.sign = (ma == mb) ? 1'b0 : sa;
        end else begin
            it.mag  = MAG_W'(mb - ma);
            it.ov   = 1'b0;
            it.sign = ~sa;
        end
        @(negedge clk);
        start = 1'b1; sub_mode = sub; a_sign = sa; a_mag = MAG_W'(ma);
        b_sign = sb_; b_mag = MAG_W'(mb);
        it.due = cyc + LAT;
        it.tag = tag;
        sb.push_back(it);
        @(negedge clk);
        // R10: scramble inputs while busy
        start = 1'b0; sub_mode = ~sub; a_sign = ~sa; a_mag = ~MAG_W'(ma);
        b_sign = ~sb_; b_mag = MAG_W'(mb) ^ 8'h5A;
        repeat (LAT + 1) @(negedge clk);
    endtask

    initial begin : monitor
        item_t it;
        forever begin
            @(negedge clk);
            if (rst_n && done) begin
                checks++;
                if (sb.size() == 0) begin
                    errors++;
                    $display("FAIL R9 unexpected done: actual done=1 expected done=0 at cyc %0d", cyc);
                end else begin
                    it = sb.pop_front();
                    if (res_sign !== it.sign || res_mag !== it.mag || ovf !== it.ov || cyc != it.due) begin
                        errors++;
                        $display("FAIL %s R9 R10: actual sign=%0b mag=%0d ovf=%0b cyc=%0d expected sign=%0b mag=%0d ovf=%0b cyc=%0d",
                                 it.tag, res_sign, res_mag, ovf, cyc, it.sign, it.mag, it.ov, it.due);
                    end
                end
            end
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog expired: actual running expected finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : driver
        repeat (3) @(negedge clk);
        checks++; // R1 reset state
        if (done !== 1'b0 || res_sign !== 1'b0 || res_mag !== '0 || ovf !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset: actual done=%0b sign=%0b mag=%0d ovf=%0b expected all 0",
                     done, res_sign, res_mag, ovf);
        end
        rst_n = 1'b1;
        op(0, 0, 5,   0, 3,   "R3 +5 + +3");
        op(0, 1, 5,   1, 3,   "R3 -5 + -3");
        op(0, 0, 200, 0, 100, "R4 +200 + +100");
        op(0, 1, 200, 1, 100, "R4 -200 + -100");
        op(0, 0, 255, 0, 1,   "R4 +255 + +1");
        op(0, 0, 0,   0, 0,   "R3 +0 + +0");
        op(1, 0, 5,   0, 3,   "R2 R6 +5 - +3");
        op(1, 0, 5,   1, 3,   "R2 R3 +5 - -3");
        op(0, 0, 3,   1, 5,   "R5 R7 +3 + -5");
        op(0, 1, 3,   0, 5,   "R7 -3 + +5");
        op(1, 0, 1,   0, 255, "R2 R7 +1 - +255");
        op(0, 1, 9,   0, 4,   "R6 -9 + +4");
        op(0, 0, 7,   1, 7,   "R8 +7 + -7");
        op(0, 1, 7,   0, 7,   "R8 -7 + +7");
        op(1, 1, 9,   1, 9,   "R8 -9 - -9");
        op(1, 0, 0,   0, 0,   "R8 +0 - +0");
        op(1, 0, 255, 0, 255, "R8 +255 - +255");
        op(1, 0, 255, 1, 255, "R2 R4 +255 - -255");
        repeat (4) @(negedge clk);
        checks++;
        if (sb.size() != 0) begin
            errors++;
            $display("FAIL R9 missing done: actual pending=%0d expected 0", sb.size());
        end
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule